// File: doc/BRIEF.md
# Dual-Port Same-Address Busy Arbiter

This block sits in front of a two-port memory array and watches the chip enables and addresses of a left port and a right port. When both ports are enabled on the same address in the same cycle, one of them is allowed to proceed. The other port receives an active-low busy indication, and its write strobe to the array is suppressed in that same cycle. The decision looks only at enables and addresses. A read and a write are treated alike.

A mode input picks between two roles. As a master, the block makes the decision itself and drives the busy outputs. As a slave, it makes no decision of its own. Its busy outputs stay high, and a pair of busy inputs, normally wired from one master, act purely as per-port write inhibits. Several slaves can then follow the verdict of a single master when memories are placed side by side to widen the word.

Priority follows arrival order. A port counts as the holder when it was enabled on the same address in the previous clock. A port that arrives later on a held address loses. When both ports arrive in the same cycle, the left port wins. The winner keeps its access for as long as both ports stay on that address. The gated write enables are combinational from the current inputs and the registered history, so busy is always valid in the cycle in which a write is issued.

Top module: `dpa_arbiter`

## Requirements
- R1: Reset clears all history. In the first cycle after reset, a contention counts as a simultaneous arrival, whatever was held before reset.
- R2: In master mode, both busy outputs are high (1) whenever the ports are not both enabled on equal addresses.
- R3: In master mode, when both ports reach the same address in the same cycle and neither was on it in the previous cycle, `rgt_busy_n` is 0 and `lft_busy_n` is 1.
- R4: In master mode, a port that was enabled on an address in the previous cycle keeps priority over a port that arrives on it later. The later port's busy output is 0.
- R5: In master mode, during any contention exactly one of the two busy outputs is 0.
- R6: The read/write inputs have no effect on either busy output.
- R7: A gated write enable is 1 exactly when its port is enabled, requests a write and is not inhibited in the same cycle. In master mode the inhibit is the port's own busy output being 0.
- R8: In slave mode, both busy outputs are held at 1, and no arbitration affects the write enables.
- R9: In slave mode, a busy input at 1 lets that port's writes through, and a busy input at 0 blocks them.
- R10: While both ports stay enabled on the same address over consecutive cycles, the winner does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | 1 = slave (busy pins are inhibit inputs), 0 = master |
| lft_en | input | 1 | Left port chip enable, active high |
| lft_addr | input | ADDR_W | Left port address |
| lft_wr | input | 1 | Left port write request (1 = write) |
| rgt_en | input | 1 | Right port chip enable, active high |
| rgt_addr | input | ADDR_W | Right port address |
| rgt_wr | input | 1 | Right port write request (1 = write) |
| lft_busy_n_in | input | 1 | Left write inhibit in slave mode, active low |
| rgt_busy_n_in | input | 1 | Right write inhibit in slave mode, active low |
| lft_busy_n | output | 1 | Left busy indication, active low |
| rgt_busy_n | output | 1 | Right busy indication, active low |
| lft_we | output | 1 | Gated left write enable to the array |
| rgt_we | output | 1 | Gated right write enable to the array |

## Verification
The hardest case to reach is a right-port win. It takes a right port that sits on an address for at least one cycle, and a left port that arrives on that address afterwards and then stays while the right port keeps its address. It also requires that no reset or address change clears the history in between. Directed sequences build this hold-then-arrive pattern. They also cover a reset applied while the right port holds its address, which must give priority back to the left. A random phase on a four-address space then produces many overlapping arrivals and departures, with both modes and all read/write mixes. Every cycle is compared against a behavioural model that tracks the current owner as an integer.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
    typedef enum logic {SIDE_LEFT = 1'b0, SIDE_RIGHT = 1'b1} side_e;
    localparam int NUM_PORTS = 2;
endpackage

// File: rtl/dpa_match.sv
// Same-address detection and "held from last cycle" tests.
module dpa_match #(
    parameter int AW = 11
) (
    input  logic          l_en,
    input  logic [AW-1:0] l_addr,
    input  logic          r_en,
    input  logic [AW-1:0] r_addr,
    input  logic          pl_en,
    input  logic [AW-1:0] pl_addr,
    input  logic          pr_en,
    input  logic [AW-1:0] pr_addr,
    output logic          coll,
    output logic          l_held,
    output logic          r_held
);
    always_comb begin
        coll   = l_en && r_en && (l_addr == r_addr);
        l_held = pl_en && (pl_addr == l_addr);
        r_held = pr_en && (pr_addr == r_addr);
    end
endmodule

// File: rtl/dpa_track.sv
// Registered history of both ports and of the last winner.
module dpa_track
    import dpa_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_en,
    input  logic [AW-1:0] l_addr,
    input  logic          r_en,
    input  logic [AW-1:0] r_addr,
    input  side_e         win,
    output logic          pl_en,
    output logic [AW-1:0] pl_addr,
    output logic          pr_en,
    output logic [AW-1:0] pr_addr,
    output side_e         p_win
);
    typedef struct packed {
        logic          l_en;
        logic [AW-1:0] l_addr;
        logic          r_en;
        logic [AW-1:0] r_addr;
        side_e         win;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d        = trk_q;
        trk_d.l_en   = l_en;
        trk_d.l_addr = l_addr;
        trk_d.r_en   = r_en;
        trk_d.r_addr = r_addr;
        trk_d.win    = win;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '{l_en: 1'b0, l_addr: '0, r_en: 1'b0, r_addr: '0, win: SIDE_LEFT};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign pl_en   = trk_q.l_en;
    assign pl_addr = trk_q.l_addr;
    assign pr_en   = trk_q.r_en;
    assign pr_addr = trk_q.r_addr;
    assign p_win   = trk_q.win;
endmodule

// File: rtl/dpa_gate.sv
// Per-port busy drive and write gating; mode picks the inhibit source.
module dpa_gate (
    input  logic slave_mode,
    input  logic lose,
    input  logic busy_n_in,
    input  logic en,
    input  logic wr,
    output logic busy_n_out,
    output logic we
);
    logic inhibit;

    always_comb begin
        inhibit    = slave_mode ? !busy_n_in : lose;
        busy_n_out = slave_mode ? 1'b1 : !lose;
        we         = en && wr && !inhibit;
    end
endmodule

// File: rtl/dpa_arbiter.sv
module dpa_arbiter
    import dpa_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              lft_en,
    input  logic [ADDR_W-1:0] lft_addr,
    input  logic              lft_wr,
    input  logic              rgt_en,
    input  logic [ADDR_W-1:0] rgt_addr,
    input  logic              rgt_wr,
    input  logic              lft_busy_n_in,
    input  logic              rgt_busy_n_in,
    output logic              lft_busy_n,
    output logic              rgt_busy_n,
    output logic              lft_we,
    output logic              rgt_we
);
    logic              pl_en, pr_en;
    logic [ADDR_W-1:0] pl_addr, pr_addr;
    side_e             p_win, win;
    logic              coll, l_held, r_held;

    logic [NUM_PORTS-1:0] en_v, wr_v, bin_v, lose_v, bout_v, we_v;

    dpa_match #(.AW(ADDR_W)) u_match (
        .l_en(lft_en), .l_addr(lft_addr), .r_en(rgt_en), .r_addr(rgt_addr),
        .pl_en(pl_en), .pl_addr(pl_addr), .pr_en(pr_en), .pr_addr(pr_addr),
        .coll(coll), .l_held(l_held), .r_held(r_held)
    );

    // Winner: both still on it -> keep last verdict; only right held -> right; else left.
    always_comb begin
        if (l_held && r_held) begin
            win = p_win;
        end else if (r_held) begin
            win = SIDE_RIGHT;
        end else begin
            win = SIDE_LEFT;
        end
    end

    dpa_track #(.AW(ADDR_W)) u_track (
        .clk(clk), .rst_n(rst_n),
        .l_en(lft_en), .l_addr(lft_addr), .r_en(rgt_en), .r_addr(rgt_addr),
        .win(win),
        .pl_en(pl_en), .pl_addr(pl_addr), .pr_en(pr_en), .pr_addr(pr_addr),
        .p_win(p_win)
    );

    always_comb begin
        en_v   = {rgt_en, lft_en};
        wr_v   = {rgt_wr, lft_wr};
        bin_v  = {rgt_busy_n_in, lft_busy_n_in};
        lose_v = {coll && (win == SIDE_LEFT), coll && (win == SIDE_RIGHT)};
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        dpa_gate u_gate (
            .slave_mode(slave_mode), .lose(lose_v[g]), .busy_n_in(bin_v[g]),
            .en(en_v[g]), .wr(wr_v[g]),
            .busy_n_out(bout_v[g]), .we(we_v[g])
        );
    end

    assign lft_busy_n = bout_v[0];
    assign rgt_busy_n = bout_v[1];
    assign lft_we     = we_v[0];
    assign rgt_we     = we_v[1];
endmodule

// File: rtl/dpa_checker.sv
module dpa_checker #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slave_mode,
    input logic              lft_en,
    input logic [ADDR_W-1:0] lft_addr,
    input logic              lft_wr,
    input logic              rgt_en,
    input logic [ADDR_W-1:0] rgt_addr,
    input logic              rgt_wr,
    input logic              lft_busy_n_in,
    input logic              rgt_busy_n_in,
    input logic              lft_busy_n,
    input logic              rgt_busy_n,
    input logic              lft_we,
    input logic              rgt_we
);
    logic              same;
    logic              h_coll, h_slave, h_lb, h_rb, h_le, h_re;
    logic [ADDR_W-1:0] h_la, h_ra;

    assign same = lft_en && rgt_en && (lft_addr == rgt_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_coll <= 1'b0; h_slave <= 1'b1; h_lb <= 1'b1; h_rb <= 1'b1;
            h_le <= 1'b0; h_re <= 1'b0; h_la <= '0; h_ra <= '0;
        end else begin
            h_coll <= same; h_slave <= slave_mode; h_lb <= lft_busy_n; h_rb <= rgt_busy_n;
            h_le <= lft_en; h_re <= rgt_en; h_la <= lft_addr; h_ra <= rgt_addr;
        end
    end

    p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && !same) |-> (lft_busy_n && rgt_busy_n));

    p_one_loser_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && same) |-> ($countones({lft_busy_n, rgt_busy_n}) == 1));

    p_left_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && same && !(h_le && h_la == lft_addr) && !(h_re && h_ra == rgt_addr))
        |-> (!rgt_busy_n && lft_busy_n));

    p_holder_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && same && (h_re && h_ra == rgt_addr) && !(h_le && h_la == lft_addr))
        |-> (!lft_busy_n && rgt_busy_n));

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && !h_slave && same && h_coll && h_la == lft_addr)
        |-> (lft_busy_n == h_lb && rgt_busy_n == h_rb));

    p_gate_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !slave_mode |-> (lft_we == (lft_en && lft_wr && lft_busy_n)));

    p_gate_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !slave_mode |-> (rgt_we == (rgt_en && rgt_wr && rgt_busy_n)));

    p_slave_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode |-> (lft_busy_n && rgt_busy_n));

    p_slave_inhibit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode |-> (lft_we == (lft_en && lft_wr && lft_busy_n_in)
                        && rgt_we == (rgt_en && rgt_wr && rgt_busy_n_in)));
endmodule

bind dpa_arbiter dpa_checker #(.ADDR_W(ADDR_W)) u_dpa_checker (.*);

// File: tb/test_dpa_arbiter.sv
module test_dpa_arbiter;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slave_mode = 1'b0;
    logic          lft_en = 1'b0, rgt_en = 1'b0, lft_wr = 1'b0, rgt_wr = 1'b0;
    logic [AW-1:0] lft_addr = '0, rgt_addr = '0;
    logic          lft_busy_n_in = 1'b1, rgt_busy_n_in = 1'b1;
    logic          lft_busy_n, rgt_busy_n, lft_we, rgt_we;

    always #5 clk = ~clk;

    dpa_arbiter #(.ADDR_W(AW)) i_dpa_arbiter (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
        .lft_en(lft_en), .lft_addr(lft_addr), .lft_wr(lft_wr),
        .rgt_en(rgt_en), .rgt_addr(rgt_addr), .rgt_wr(rgt_wr),
        .lft_busy_n_in(lft_busy_n_in), .rgt_busy_n_in(rgt_busy_n_in),
        .lft_busy_n(lft_busy_n), .rgt_busy_n(rgt_busy_n),
        .lft_we(lft_we), .rgt_we(rgt_we)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Behavioural model: previous-cycle view and owner (-1 none, 0 left, 1 right).
    bit ple = 0, pre = 0;
    int pla = 0, pra = 0, pown = -1, own_now = -1;

    function automatic int owner_now();
        bit c, lh, rh;
        c  = lft_en && rgt_en && (int'(lft_addr) == int'(rgt_addr));
        lh = ple && (pla == int'(lft_addr));
        rh = pre && (pra == int'(rgt_addr));
        if (!c) return -1;
        if (lh && rh) return pown;
        if (rh) return 1;
        return 0;
    endfunction

    task automatic cmp(string tag, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_now(string tag);
        logic eb_l, eb_r, ew_l, ew_r;
        if (slave_mode) begin
            eb_l = 1'b1; eb_r = 1'b1;
            ew_l = lft_en && lft_wr && lft_busy_n_in;
            ew_r = rgt_en && rgt_wr && rgt_busy_n_in;
        end else begin
            eb_l = !(own_now == 1);
            eb_r = !(own_now == 0);
            ew_l = lft_en && lft_wr && eb_l;
            ew_r = rgt_en && rgt_wr && eb_r;
        end
        cmp(tag, "lft_busy_n", lft_busy_n, eb_l);
        cmp(tag, "rgt_busy_n", rgt_busy_n, eb_r);
        cmp(tag, "lft_we", lft_we, ew_l);
        cmp(tag, "rgt_we", rgt_we, ew_r);
    endtask

    // Inputs are set at posedge+1; check at posedge+4; model advances at the edge.
    task automatic step(string tag, bit do_chk = 1'b1);
        own_now = owner_now();
        #3;
        if (do_chk) check_now(tag);
        @(posedge clk);
        if (!rst_n) begin
            ple = 0; pre = 0; pla = 0; pra = 0; pown = -1;
        end else begin
            ple = lft_en; pre = rgt_en; pla = int'(lft_addr); pra = int'(rgt_addr); pown = own_now;
        end
        #1;
    endtask

    task automatic drive(bit le, int la, bit lw, bit re, int ra, bit rw);
        lft_en = le; lft_addr = AW'(la); lft_wr = lw;
        rgt_en = re; rgt_addr = AW'(ra); rgt_wr = rw;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        step("R1", 1'b0);
        rst_n = 1'b1;
        // R1: idle after reset
        step("R1");
        // R2: distinct addresses, both writing
        drive(1, 16, 1, 1, 17, 1);
        step("R2");
        // R3: simultaneous arrival, left wins, right write gated (R7)
        drive(1, 'h7FE, 1, 1, 'h7FE, 1);
        step("R3");
        // R10: both stay, verdict kept
        step("R10");
        step("R10");
        // left leaves; right alone on 7FE
        drive(1, 3, 1, 1, 'h7FE, 0);
        step("R2");
        // R4: left returns while right holds -> right wins, left write blocked (R7)
        drive(1, 'h7FE, 1, 1, 'h7FE, 0);
        step("R4");
        step("R10");
        // R6: same hold with read/write swapped must keep same busy
        drive(1, 'h7FE, 0, 1, 'h7FE, 1);
        step("R6");
        // R5: right drops enable, then both back at once -> left wins
        drive(1, 'h7FE, 1, 0, 'h7FE, 1);
        step("R2");
        drive(1, 9, 0, 1, 9, 0);
        step("R5");
        // R1: right holds, reset mid-stream, then simultaneous contention
        drive(0, 0, 0, 1, 'h7FF, 1);
        step("R4");
        step("R4");
        rst_n = 1'b0;
        step("R1", 1'b0);
        rst_n = 1'b1;
        drive(1, 'h7FF, 1, 1, 'h7FF, 1);
        step("R1");
        // R8/R9: slave mode, contention ignored, inhibits from inputs
        slave_mode = 1'b1;
        lft_busy_n_in = 1'b1; rgt_busy_n_in = 1'b1;
        step("R8");
        lft_busy_n_in = 1'b0; rgt_busy_n_in = 1'b1;
        step("R9");
        lft_busy_n_in = 1'b1; rgt_busy_n_in = 1'b0;
        drive(1, 4, 1, 1, 5, 1);
        step("R9");
        lft_busy_n_in = 1'b0; rgt_busy_n_in = 1'b0;
        step("R9");
        slave_mode = 1'b0;
        lft_busy_n_in = 1'b1; rgt_busy_n_in = 1'b1;
        step("R2");
        // Random phase on a small address space
        for (int i = 0; i < 4000; i++) begin
            string tag;
            drive(($urandom % 4) != 0, $urandom % 4, $urandom % 2,
                  ($urandom % 4) != 0, $urandom % 4, $urandom % 2);
            if (($urandom % 16) == 0) slave_mode = ~slave_mode;
            lft_busy_n_in = ($urandom % 3) != 0;
            rgt_busy_n_in = ($urandom % 3) != 0;
            if (slave_mode) tag = "R9";
            else if (lft_en && rgt_en && lft_addr == rgt_addr) tag = "R4";
            else tag = "R2";
            step(tag);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule